// File: doc/BRIEF.md
# Successive-approximation converter controller with shared start/read strobes

This block is the digital core of an 8-bit successive-approximation converter that sits on a microprocessor bus. Two active-low strobes, chip-select and read, serve two purposes at once. Lowering both starts a conversion, and the same access reads the result that is already stored. The block steps a binary-search register against a one-bit comparator decision and drives the trial code to an external DAC. It commands an external track/hold to hold the input, and it reports progress on an active-low busy flag.

Two bus styles are supported. In the wait-state style, the host keeps both strobes low through the whole conversion and treats busy as a wait request. It then takes the new result when busy returns high. In the two-read style, a short first access starts the conversion and returns stale data, and a second access after busy rises fetches the new code. A second access that comes too soon after busy rises only reads the data and does not start a new conversion.

The block has no streaming payload, so no valid/ready handshake is used and there is no back-pressure. The data pins carry the stored code together with a drive-enable, and the pad-level three-state buffer sits outside the block. Strobes are asynchronous and are synchronized internally. Comparator decisions are taken on the block clock.

Top module: `sar_bus_ctl`

## Requirements
- R1: A conversion starts only when cs_n and rd_n are both low. busy_n falls on the third rising clock edge after the moment both strobes are low. One strobe low on its own never starts a conversion.
- R2: busy_n stays low for exactly 20 clock cycles. On the edge where busy_n returns high, the new code is already present on data_o.
- R3: hold (1 = hold, 0 = track) rises on the third rising edge after busy_n falls. hold is low whenever busy_n is high.
- R4: The search runs from bit 7 (MSB) to bit 0 and produces a straight binary code. dac_code is 0 for the first four clocks of a conversion and 0x80 from the fifth. Each trial bit is kept if cmp_i was 1 one clock before the decision edge. With cmp_i = (held value >= dac_code), the result equals the held value for every code 0 to 255.
- R5: While busy_n is high, dac_code does not change.
- R6: data_oe is 1 exactly while cs_n and rd_n are both low. data_o shows the stored code.
- R7: A read issued during a conversion returns the previous result. A new strobe access during a conversion is ignored and does not lengthen it.
- R8: If both strobes are already low at the first rising edge after busy_n returns high, no conversion starts. The access only reads the new code. If the strobes fall one clock later, a conversion starts normally.
- R9: A conversion starts on the falling of the combined strobe, not on its level. Keeping both strobes low after busy_n rises starts nothing.
- R10: After reset, busy_n = 1, hold = 0, dac_code = 0 and data_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| cmp_i | input | 1 | Comparator decision: 1 when held input >= dac_code |
| busy_n | output | 1 | Active-low conversion in progress |
| hold | output | 1 | Track/hold command, 1 = hold |
| dac_code | output | 8 | Trial code to the DAC |
| data_o | output | 8 | Stored conversion result |
| data_oe | output | 1 | Drive-enable for the data bus |

## Verification
Counting from the clock edge after both strobes fall, busy_n is due low at edge 3 and hold is due high at edge 6. dac_code is due to reach 0x80 at edge 7, and busy_n together with the new code is due at edge 23. data_oe follows the strobes with no clock delay. The bench changes strobes and samples every output on the falling clock edge, and it counts falling edges from each stimulus to the exact cycle where a result is due. The sweep converts all 256 codes with a behavioural comparator that captures its input on the rising edge of hold. Restart suppression is probed at the last suppressed strobe position and at the first position that is allowed.

// File: rtl/sar_bus_ctl_pkg.sv
package sar_bus_ctl_pkg;
  // Input clocks per conversion: one clear cycle, WIDTH trial cycles and one
  // final cycle of the divided clock, each two input clocks long.
  function automatic int conv_cycles(input int width);
    return 2 * (width + 2);
  endfunction

  // Width of the divided-clock step index.
  function automatic int step_bits(input int width);
    return $clog2(conv_cycles(width)) - 1;
  endfunction
endpackage

// File: rtl/sar_strobe_sync.sv
module sar_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  output logic req_rise
);
  logic [STAGES-1:0] cs_sh, rd_sh;
  logic [STAGES:0]   cs_ext, rd_ext;
  logic              req, req_q;

  assign cs_ext = {cs_sh, ~cs_n};
  assign rd_ext = {rd_sh, ~rd_n};
  assign req    = cs_ext[STAGES] & rd_ext[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh <= '0;
      rd_sh <= '0;
      req_q <= 1'b0;
    end else begin
      cs_sh <= cs_ext[STAGES-1:0];
      rd_sh <= rd_ext[STAGES-1:0];
      req_q <= req;
    end
  end

  // Edge of the combined request: a level held low never retriggers.
  assign req_rise = req & ~req_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_bus_ctl_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int GUARD_CYC = 3,
  localparam int KW       = step_bits(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rise,
  output logic          busy_n,
  output logic          hold,
  output logic          sar_clr,
  output logic          step_en,
  output logic [KW-1:0] step_k,
  output logic          done
);
  localparam int CONV_CYC = conv_cycles(WIDTH);
  localparam int TW       = KW + 1;
  localparam int GW       = $clog2(GUARD_CYC + 2);
  localparam logic [TW-1:0] T_HOLD = TW'(2);
  localparam logic [TW-1:0] T_LAST = TW'(CONV_CYC - 1);
  localparam logic [GW-1:0] G_INIT = GW'(GUARD_CYC);

  logic          active;
  logic [TW-1:0] t;
  logic [GW-1:0] guard;
  logic          start;

  assign start = req_rise && !active && (guard == '0);
  assign done  = active && (t == T_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      t      <= '0;
      hold   <= 1'b0;
      guard  <= '0;
    end else begin
      if (start) begin
        active <= 1'b1;
        t      <= '0;
      end else if (done) begin
        active <= 1'b0;
        t      <= '0;
      end else if (active) begin
        t <= t + 1'b1;
      end

      if (start || done)               hold <= 1'b0;
      else if (active && t == T_HOLD)  hold <= 1'b1;

      if (done)              guard <= G_INIT;
      else if (guard != '0)  guard <= guard - 1'b1;
    end
  end

  // Divided clock: a step on the second input clock of each internal cycle;
  // nothing toggles while idle.
  assign busy_n  = ~active;
  assign sar_clr = start;
  assign step_en = active & t[0];
  assign step_k  = t[TW-1:1];
endmodule

// File: rtl/sar_shift_reg.sv
module sar_shift_reg #(
  parameter int WIDTH = 8,
  parameter int KW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step_en,
  input  logic [KW-1:0]    step_k,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] result
);
  logic             cmp_q;
  logic [WIDTH-1:0] code_nx;

  // Bit i is tried at step WIDTH-i and decided one step later.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam logic [KW-1:0] K_TRY = KW'(WIDTH - i);
    localparam logic [KW-1:0] K_DEC = KW'(WIDTH - i + 1);
    assign code_nx[i] = clr                             ? 1'b0  :
                        (step_en && step_k == K_TRY)    ? 1'b1  :
                        (step_en && step_k == K_DEC)    ? cmp_q :
                                                          code[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      cmp_q <= 1'b0;
    end else begin
      code  <= code_nx;
      cmp_q <= cmp_i;
    end
  end

  // LSB decision is taken on the final edge, so it bypasses the register.
  assign result = {code[WIDTH-1:1], cmp_q};
endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] result,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_o <= '0;
    else if (load) data_o <= result;
  end

  assign data_oe = ~cs_n & ~rd_n;
endmodule

// File: rtl/sar_bus_ctl.sv
module sar_bus_ctl
  import sar_bus_ctl_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             cmp_i,
  output logic             busy_n,
  output logic             hold,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe
);
  localparam int KW = step_bits(WIDTH);

  logic             req_rise, sar_clr, step_en, done;
  logic [KW-1:0]    step_k;
  logic [WIDTH-1:0] result;

  sar_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .req_rise(req_rise)
  );

  sar_conv_seq #(.WIDTH(WIDTH), .GUARD_CYC(GUARD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_rise(req_rise), .busy_n(busy_n),
    .hold(hold), .sar_clr(sar_clr), .step_en(step_en), .step_k(step_k),
    .done(done)
  );

  sar_shift_reg #(.WIDTH(WIDTH), .KW(KW)) u_sar (
    .clk(clk), .rst_n(rst_n), .clr(sar_clr), .step_en(step_en),
    .step_k(step_k), .cmp_i(cmp_i), .code(dac_code), .result(result)
  );

  sar_out_latch #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(rst_n), .load(done), .result(result),
    .cs_n(cs_n), .rd_n(rd_n), .data_o(data_o), .data_oe(data_oe)
  );
endmodule

// File: rtl/sar_bus_ctl_chk.sv
module sar_bus_ctl_chk #(
  parameter int WIDTH    = 8,
  parameter int CONV_CYC = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_n,
  input logic             hold,
  input logic [WIDTH-1:0] dac_code,
  input logic [WIDTH-1:0] data_o
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_cnt <= '0;
    else if (busy_n)            low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> low_cnt == 16'(CONV_CYC)); // R2
  AST_HOLD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> low_cnt == 16'd3); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !hold); // R3
  AST_DAC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n && $past(busy_n) |-> $stable(dac_code)); // R5
  AST_OLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> $stable(data_o)); // R7
  AST_NO_QUICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |=> busy_n); // R8
endmodule

bind sar_bus_ctl sar_bus_ctl_chk #(
  .WIDTH(WIDTH), .CONV_CYC(2 * (WIDTH + 2))
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .hold(hold),
  .dac_code(dac_code), .data_o(data_o)
);

// File: tb/sar_bus_ctl_bench.sv
module sar_bus_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1;
  logic       cmp;
  logic       busy_n, hold, data_oe;
  logic [7:0] dac_code, data_o;
  logic [7:0] ain = 8'd0, held = 8'd0;
  int checks = 0, failures = 0;
  int low_run = 0, last_len = 0, nconv = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  sar_bus_ctl u_sar_bus_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .cmp_i(cmp),
    .busy_n(busy_n), .hold(hold), .dac_code(dac_code), .data_o(data_o),
    .data_oe(data_oe)
  );

  // Behavioural track/hold and comparator.
  always @(posedge hold) held = ain;
  assign cmp = (held >= dac_code);

  // Busy-length monitor sampled on falling edges.
  always @(negedge clk) begin
    if (rst_n && !busy_n) low_run++;
    else if (low_run != 0) begin
      last_len = low_run;
      low_run  = 0;
      nconv++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input logic lvl);
    cs_n = lvl;
    rd_n = lvl;
  endtask

  task automatic wait_busy_high();
    for (int k = 0; k < 60 && !busy_n; k++) @(negedge clk);
  endtask

  // Wait-state style conversion of value v; old is the previously stored code.
  task automatic run_slow(input logic [7:0] v, input logic [7:0] old);
    int k;
    logic [7:0] d0;
    @(negedge clk);
    ain = v;
    strobes(1'b0);
    #1;
    chk(data_oe == 1'b1, "R6 enable with strobes low", data_oe, 1);
    chk(data_o == old, "R7 old data at start", data_o, old);
    tick(2);
    chk(busy_n == 1'b1, "R1 not before third edge", busy_n, 1);
    tick(1);
    chk(busy_n == 1'b0, "R1 busy on third edge", busy_n, 0);
    chk(dac_code == 8'd0, "R4 cleared at start", dac_code, 0);
    tick(2);
    chk(hold == 1'b0, "R3 track before hold edge", hold, 0);
    tick(1);
    chk(hold == 1'b1, "R3 hold on third edge", hold, 1);
    chk(dac_code == 8'd0, "R4 still cleared", dac_code, 0);
    tick(1);
    chk(dac_code == 8'h80, "R4 MSB trial", dac_code, 128);
    ain = ~v;  // input moves after hold
    k = 4;
    while (!busy_n && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk(k == 20, "R2 busy length", k, 20);
    chk(data_o == v, "R4 converted code", data_o, v);
    chk(hold == 1'b0, "R3 track after conversion", hold, 0);
    tick(6);
    chk(busy_n == 1'b1, "R9 held strobes do not restart", busy_n, 1);
    strobes(1'b1);
    tick(2);
    chk(data_oe == 1'b0, "R6 enable off", data_oe, 0);
    d0 = dac_code;
    tick(4);
    chk(dac_code == d0, "R5 idle DAC frozen", dac_code, d0);
  endtask

  task automatic pulse();
    @(negedge clk);
    strobes(1'b0);
    tick(3);
    strobes(1'b1);
  endtask

  initial begin
    int n0;
    tick(3);
    #1;
    chk(busy_n == 1'b1, "R10 busy_n reset", busy_n, 1);
    chk(hold == 1'b0, "R10 hold reset", hold, 0);
    chk(dac_code == 8'd0, "R10 dac reset", dac_code, 0);
    chk(data_o == 8'd0, "R10 data reset", data_o, 0);
    chk(data_oe == 1'b0, "R6 enable off at idle", data_oe, 0);
    rst_n = 1'b1;
    tick(2);

    // One strobe alone
    cs_n = 1'b0;
    tick(6);
    chk(busy_n == 1'b1, "R1 chip-select alone", busy_n, 1);
    chk(data_oe == 1'b0, "R6 one strobe no enable", data_oe, 0);
    cs_n = 1'b1;
    tick(4);

    // Exhaustive sweep
    for (int v = 0; v < 256; v++) run_slow(8'(v), (v == 0) ? 8'd0 : 8'(v - 1));

    // Two-read style with an access during conversion
    n0 = nconv;
    ain = 8'h5A;
    @(negedge clk);
    strobes(1'b0);
    #1;
    chk(data_o == 8'hFF, "R7 first read returns stale code", data_o, 255);
    tick(3);
    strobes(1'b1);
    tick(5);
    strobes(1'b0);
    #1;
    chk(busy_n == 1'b0, "R7 read during conversion", busy_n, 0);
    chk(data_o == 8'hFF, "R7 previous result mid-conversion", data_o, 255);
    tick(3);
    strobes(1'b1);
    wait_busy_high();
    // Strobes low before the first edge after busy_n rises: suppressed
    strobes(1'b0);
    #1;
    chk(data_o == 8'h5A, "R8 suppressed access reads new code", data_o, 90);
    chk(data_oe == 1'b1, "R8 suppressed access drives bus", data_oe, 1);
    tick(8);
    chk(busy_n == 1'b1, "R8 no restart", busy_n, 1);
    chk(nconv == n0 + 1, "R7 one conversion only", nconv, n0 + 1);
    chk(last_len == 20, "R7 length unchanged", last_len, 20);
    strobes(1'b1);
    tick(4);

    // One clock later: allowed
    ain = 8'h33;
    pulse();
    wait_busy_high();
    chk(data_o == 8'h33, "R2 two-read result", data_o, 51);
    ain = 8'hC4;
    @(negedge clk);
    strobes(1'b0);
    tick(3);
    chk(busy_n == 1'b0, "R8 start one clock later", busy_n, 0);
    wait_busy_high();
    chk(data_o == 8'hC4, "R8 allowed conversion result", data_o, 196);
    strobes(1'b1);
    tick(4);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule